// File: doc/BRIEF.md
# Sync Source Priority Selector with Clamp Pulse

This block sits behind the sync slicers of a multi-scan display input. It receives three cleaned-up, active-high sync sources, each with a flag that says whether a signal is there: sync-on-green, horizontal/composite, and a separate vertical input. It also receives the vertical sync that has already been separated from composite. A two-bit mode input sets the source priority. The block chooses one source for the horizontal output and one for the vertical output. It then generates a clamp pulse of programmable width on the leading or trailing edge of the chosen horizontal sync.

Each output path is a small gate state machine. ST OFF (`GATE_OFF`) drives low with nothing selected. ARM (`GATE_ARM`) holds a chosen source but keeps the output low until that source is seen low. PASS (`GATE_PASS`) forwards the source. The transitions are as follows. OFF goes to ARM when a source becomes wanted. ARM goes to PASS when the chosen source is low. ARM retargets, and stays in ARM, when the wanted source changes. ARM goes to OFF when nothing is wanted. PASS leaves, to ARM or to OFF, only when the wanted source differs and the current source is low.

The clamp generator has two states. `CLP_IDLE` goes to `CLP_HOLD` on a trigger edge when the width is non-zero. `CLP_HOLD` returns to `CLP_IDLE` after the programmed count of cycles.

Top module: `sync_source_selector`

## Requirements
- R1: Mode encoding: `mode_i` 2'b00 is low, 2'b01 is mid, and 2'b10 and 2'b11 are both high. In low or high mode the horizontal selection is composite when `comp_ok_i` is 1. Otherwise it is green when `green_ok_i` is 1. Otherwise it is none.
- R2: In mid mode the horizontal selection is green when `green_ok_i` is 1, and none otherwise, whatever `comp_ok_i` is.
- R3: In low or high mode the vertical selection is the separate vertical input when `vsep_ok_i` is 1. Otherwise it is the separated vertical sync when `green_ok_i` or `comp_ok_i` is 1. Otherwise it is none.
- R4: In mid mode the vertical selection is the separate vertical input when `vsep_ok_i` is 1. Otherwise it is the separated vertical sync only when `green_ok_i` is 1. Otherwise it is none.
- R5: In steady state each output equals its selected sync input as it was two clock edges earlier. Inputs that are not selected have no effect. With no selection the output is 0.
- R6: A change of selection takes effect only while the previously forwarded source is low, so a pulse in progress is never cut short. A newly selected source is forwarded only after it has been seen low, so no partial pulse appears.
- R7: In low or mid mode, and in high mode when the horizontal selection is green, the clamp is triggered by a falling edge of `h_sync_o`.
- R8: In high mode with composite selected for the horizontal output, the clamp is triggered by a rising edge of `h_sync_o`.
- R9: A trigger makes `clamp_o` high from the next clock edge for exactly `clamp_width_i` cycles, using the width sampled in the trigger cycle. A width of 0 produces no pulse.
- R10: A trigger that arrives while `clamp_o` is high is ignored.
- R11: While `rst_n` is low, and in the first cycle after it rises, `h_sync_o`, `v_sync_o` and `clamp_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Priority/clamp mode: 00 low, 01 mid, 10/11 high |
| green_sync_i | input | 1 | Sync separated from green, active high |
| green_ok_i | input | 1 | Green sync present |
| comp_sync_i | input | 1 | Horizontal/composite sync, active high |
| comp_ok_i | input | 1 | Horizontal/composite sync present |
| vsep_sync_i | input | 1 | Separate vertical sync, active high |
| vsep_ok_i | input | 1 | Separate vertical sync present |
| vcs_sync_i | input | 1 | Vertical sync separated from composite |
| clamp_width_i | input | CW | Clamp pulse width in clock cycles |
| h_sync_o | output | 1 | Selected horizontal sync |
| v_sync_o | output | 1 | Selected vertical sync |
| clamp_o | output | 1 | Clamp pulse |

## Verification
Two of the block's functions can meet in the same cycle. A horizontal edge can qualify as a clamp trigger while a clamp pulse is still running. Separately, a change of selection can fall on the trailing edge of the old source. The first case is provoked on purpose by toggling the composite input every cycle with a long clamp width. It is also provoked by random toggling across many mode and flag combinations. A bench-side model of the pulse checks every cycle that such edges neither restart nor extend the pulse. The second case is provoked by removing the composite flag halfway through a long composite pulse while green is held high. The bench then checks that the old pulse runs to its natural end and that green appears only from its next rising edge.

// File: rtl/sync_sel_pkg.sv
`timescale 1ns/1ps
package sync_sel_pkg;

    // Operating mode as decoded from the two-bit mode pins.
    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_MID  = 2'b01,
        MODE_HIGH = 2'b10,
        MODE_HALT = 2'b11   // alias of high mode
    } mode_e;

    // Source choice for one output path (A/B meaning depends on the path).
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2
    } src_sel_e;

    // Glitch-free gate for one output path.
    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_ARM  = 2'd1,
        GATE_PASS = 2'd2
    } gate_state_e;

    // Clamp pulse generator.
    typedef enum logic {
        CLP_IDLE = 1'b0,
        CLP_HOLD = 1'b1
    } clamp_state_e;

    function automatic logic mode_is_high(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/sync_sel_policy.sv
`timescale 1ns/1ps
// Combinational priority decode: which source each path should carry.
module sync_sel_policy
    import sync_sel_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       green_ok_i,
    input  logic       comp_ok_i,
    input  logic       vsep_ok_i,
    output src_sel_e   h_want_o,   // A = green, B = composite
    output src_sel_e   v_want_o    // A = separate vertical, B = separated from composite
);

    mode_e mode;
    assign mode = mode_e'(mode_i);

    always_comb begin
        h_want_o = SRC_NONE;
        v_want_o = SRC_NONE;
        unique case (mode)
            MODE_MID: begin
                if (green_ok_i) h_want_o = SRC_A;
                if (vsep_ok_i)       v_want_o = SRC_A;
                else if (green_ok_i) v_want_o = SRC_B;
            end
            MODE_LOW, MODE_HIGH, MODE_HALT: begin
                if (comp_ok_i)       h_want_o = SRC_B;
                else if (green_ok_i) h_want_o = SRC_A;
                if (vsep_ok_i)                    v_want_o = SRC_A;
                else if (green_ok_i || comp_ok_i) v_want_o = SRC_B;
            end
            default: begin
                h_want_o = SRC_NONE;
                v_want_o = SRC_NONE;
            end
        endcase
    end

endmodule

// File: rtl/sync_path_gate.sv
`timescale 1ns/1ps
// One output path: follows the wanted source, but only switches while the
// forwarded level is low and only starts forwarding from a low level.
module sync_path_gate
    import sync_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     src_a_i,
    input  logic     src_b_i,
    input  src_sel_e want_i,
    output logic     sync_o,
    output src_sel_e sel_o
);

    gate_state_e state_q, state_d;
    src_sel_e    sel_q, sel_d;
    logic        out_q, out_d;
    logic        cur_lvl;

    always_comb begin
        unique case (sel_q)
            SRC_A:   cur_lvl = src_a_i;
            SRC_B:   cur_lvl = src_b_i;
            default: cur_lvl = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OFF;
            sel_q   <= SRC_NONE;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            GATE_OFF: begin
                if (want_i != SRC_NONE) begin
                    state_d = GATE_ARM;
                    sel_d   = want_i;
                end
            end
            GATE_ARM: begin
                if (want_i != sel_q) begin
                    if (want_i == SRC_NONE) state_d = GATE_OFF;
                    sel_d = want_i;
                end else if (!cur_lvl) begin
                    state_d = GATE_PASS;
                end
            end
            GATE_PASS: begin
                if ((want_i != sel_q) && !cur_lvl) begin
                    state_d = (want_i == SRC_NONE) ? GATE_OFF : GATE_ARM;
                    sel_d   = want_i;
                end
            end
            default: begin
                state_d = GATE_OFF;
                sel_d   = SRC_NONE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        out_d = (state_q == GATE_PASS) ? cur_lvl : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign sync_o = out_q;
    assign sel_o  = sel_q;

endmodule

// File: rtl/sync_clamp_gen.sv
`timescale 1ns/1ps
// Fixed-width clamp pulse on a selectable edge of the horizontal output.
module sync_clamp_gen
    import sync_sel_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic          lead_i,
    input  logic [CW-1:0] width_i,
    output logic          clamp_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    clamp_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          line_prev_q;
    logic          trig;

    always_comb begin
        trig = lead_i ? (line_i && !line_prev_q) : (!line_i && line_prev_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= CLP_IDLE;
            cnt_q       <= '0;
            line_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            line_prev_q <= line_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CLP_IDLE: begin
                if (trig && (width_i != '0)) begin
                    state_d = CLP_HOLD;
                    cnt_d   = width_i;
                end
            end
            CLP_HOLD: begin
                if (cnt_q <= ONE) begin
                    state_d = CLP_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                state_d = CLP_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        clamp_o = (state_q == CLP_HOLD);
    end

endmodule

// File: rtl/sync_source_selector.sv
`timescale 1ns/1ps
module sync_source_selector
    import sync_sel_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          green_sync_i,
    input  logic          green_ok_i,
    input  logic          comp_sync_i,
    input  logic          comp_ok_i,
    input  logic          vsep_sync_i,
    input  logic          vsep_ok_i,
    input  logic          vcs_sync_i,
    input  logic [CW-1:0] clamp_width_i,
    output logic          h_sync_o,
    output logic          v_sync_o,
    output logic          clamp_o
);

    localparam int NUM_PATH = 2;               // 0 = horizontal, 1 = vertical
    localparam int NUM_SYNC = 2 * NUM_PATH;    // two candidate sources per path

    logic [NUM_SYNC-1:0] pin_vec, sync_q;
    src_sel_e            want   [NUM_PATH];
    src_sel_e            sel    [NUM_PATH];
    logic [NUM_PATH-1:0] path_out;
    src_sel_e            h_want, v_want;
    src_sel_e            h_sel;
    logic                lead_sel;

    // Bit 2p is source A of path p, bit 2p+1 is source B.
    assign pin_vec = {vcs_sync_i, vsep_sync_i, comp_sync_i, green_sync_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_vec;
    end

    sync_sel_policy u_policy (
        .mode_i     (mode_i),
        .green_ok_i (green_ok_i),
        .comp_ok_i  (comp_ok_i),
        .vsep_ok_i  (vsep_ok_i),
        .h_want_o   (h_want),
        .v_want_o   (v_want)
    );

    assign want[0] = h_want;
    assign want[1] = v_want;

    for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
        sync_path_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_a_i (sync_q[2*p]),
            .src_b_i (sync_q[2*p+1]),
            .want_i  (want[p]),
            .sync_o  (path_out[p]),
            .sel_o   (sel[p])
        );
    end

    assign h_sel    = sel[0];
    assign lead_sel = mode_is_high(mode_i) && (h_sel == SRC_B);

    sync_clamp_gen #(.CW(CW)) u_clamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (path_out[0]),
        .lead_i  (lead_sel),
        .width_i (clamp_width_i),
        .clamp_o (clamp_o)
    );

    assign h_sync_o = path_out[0];
    assign v_sync_o = path_out[1];

endmodule

// File: rtl/sync_source_selector_chk.sv
`timescale 1ns/1ps
module sync_source_selector_chk
    import sync_sel_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          green_sync_i,
    input logic          comp_sync_i,
    input logic          vsep_sync_i,
    input logic          vcs_sync_i,
    input logic [CW-1:0] clamp_width_i,
    input logic          h_sync_o,
    input logic          v_sync_o,
    input logic          clamp_o,
    input src_sel_e      h_sel
);

    logic [CW:0]   run_q;
    logic [CW-1:0] wcap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            wcap_q <= '0;
        end else begin
            run_q <= clamp_o ? run_q + 1'b1 : '0;
            if (!clamp_o) wcap_q <= clamp_width_i;
        end
    end

    // R5: both horizontal candidates low two edges earlier -> output low
    p_h_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!green_sync_i && !comp_sync_i) |=> ##1 !h_sync_o);

    // R5: both vertical candidates low two edges earlier -> output low
    p_v_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsep_sync_i && !vcs_sync_i) |=> ##1 !v_sync_o);

    // R6: a rising output edge needs a held selection
    p_h_rise_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_sync_o) |-> ($past(h_sel) != SRC_NONE));

    // R7/R8: clamp starts only after an edge of the horizontal output
    p_clamp_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_o) |-> ($past(h_sync_o) != $past(h_sync_o, 2)));

    // R9/R10: clamp never exceeds the captured width
    p_clamp_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_o |-> ({1'b0, wcap_q} > run_q));

    // R9/R10: clamp ends exactly at the captured width
    p_clamp_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_o) |-> (run_q == {1'b0, wcap_q}));

endmodule

bind sync_source_selector sync_source_selector_chk #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .green_sync_i  (green_sync_i),
    .comp_sync_i   (comp_sync_i),
    .vsep_sync_i   (vsep_sync_i),
    .vcs_sync_i    (vcs_sync_i),
    .clamp_width_i (clamp_width_i),
    .h_sync_o      (h_sync_o),
    .v_sync_o      (v_sync_o),
    .clamp_o       (clamp_o),
    .h_sel         (h_sel)
);

// File: tb/sync_source_selector_tb.sv
`timescale 1ns/1ps
module sync_source_selector_tb;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          g_ok = 1'b0, c_ok = 1'b0, vs_ok = 1'b0;
    logic [CW-1:0] width = '0;
    logic [3:0]    pins = '0;       // [0] green [1] comp [2] vsep [3] vcs
    logic [3:0]    pins_next = '0;
    logic          h_o, v_o, cl_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // model state
    logic [3:0] d1 = '0, d2 = '0;  // pins driven one and two ticks ago
    logic       h_prev_exp = 1'b0;
    int         cl_left = 0;

    always #10 clk = ~clk;          // 50 MHz

    sync_source_selector #(.CW(CW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .green_sync_i  (pins[0]),
        .green_ok_i    (g_ok),
        .comp_sync_i   (pins[1]),
        .comp_ok_i     (c_ok),
        .vsep_sync_i   (pins[2]),
        .vsep_ok_i     (vs_ok),
        .vcs_sync_i    (pins[3]),
        .clamp_width_i (width),
        .h_sync_o      (h_o),
        .v_sync_o      (v_o),
        .clamp_o       (cl_o)
    );

    function automatic int h_pick(logic [1:0] m, logic g, logic c);
        if (m == 2'b01) return g ? 1 : 0;
        return c ? 2 : (g ? 1 : 0);
    endfunction

    function automatic int v_pick(logic [1:0] m, logic g, logic c, logic vs);
        if (vs) return 1;
        if (m == 2'b01) return g ? 2 : 0;
        return (g || c) ? 2 : 0;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    // One modelled cycle: sample and check at negedge, then drive pins_next.
    task automatic step(string ctag);
        int  hp, vp;
        logic eh, ev, ec, lead, trig;
        string ht, vt, ct;
        @(negedge clk);
        hp = h_pick(mode, g_ok, c_ok);
        vp = v_pick(mode, g_ok, c_ok, vs_ok);
        eh = (hp == 1) ? d2[0] : (hp == 2) ? d2[1] : 1'b0;
        ev = (vp == 1) ? d2[2] : (vp == 2) ? d2[3] : 1'b0;
        ht = (mode == 2'b01) ? "R2 R5" : "R1 R5";
        vt = (mode == 2'b01) ? "R4 R5" : "R3 R5";
        lead = mode[1] && (hp == 2);
        ct = (ctag != "") ? ctag : (width == 0) ? "R9" : lead ? "R8 R9" : "R7 R9";
        check(ht, h_o, eh);
        check(vt, v_o, ev);
        ec = (cl_left > 0);
        check(ct, cl_o, ec);
        trig = lead ? (eh && !h_prev_exp) : (!eh && h_prev_exp);
        if (cl_left > 0) cl_left--;
        else if (trig && width != 0) cl_left = int'(width);
        h_prev_exp = eh;
        d2 = d1;
        d1 = pins_next;
        pins = pins_next;
    endtask

    task automatic set_cfg(logic [1:0] m, logic g, logic c, logic vs, logic [CW-1:0] w);
        pins_next = '0;
        repeat (4) step("");
        @(negedge clk);
        // config change at a negedge; keep the model aligned by re-entering step
        mode = m; g_ok = g; c_ok = c; vs_ok = vs; width = w;
        // this negedge consumed without sampling: advance model history
        d2 = d1; d1 = pins_next; pins = pins_next;
        if (cl_left > 0) cl_left--;
        repeat (6) step("");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pins = '0; pins_next = '0; d1 = '0; d2 = '0;
        h_prev_exp = 1'b0; cl_left = 0;
        repeat (3) @(negedge clk);
        check("R11", h_o, 1'b0);
        check("R11", v_o, 1'b0);
        check("R11", cl_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", h_o, 1'b0);
        check("R11", cl_o, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));

        // ---- reset state (R11)
        do_reset();

        // ---- R6 directed: switch during a pulse, no truncation, no runt
        mode = 2'b00; g_ok = 1; c_ok = 1; vs_ok = 0; width = 8'd2;
        repeat (5) @(negedge clk);
        pins = 4'b0011;                       // green and comp high
        repeat (3) @(negedge clk);
        check("R1 R5", h_o, 1'b1);            // composite forwarded
        c_ok = 0;                              // wanted becomes green mid-pulse
        repeat (4) @(negedge clk);
        check("R6", h_o, 1'b1);               // old pulse not cut
        pins = 4'b0001;                       // comp falls, green still high
        repeat (3) @(negedge clk);
        check("R6", h_o, 1'b0);
        repeat (4) @(negedge clk);
        check("R6", h_o, 1'b0);               // green mid-pulse not forwarded
        pins = 4'b0000;
        repeat (3) @(negedge clk);
        pins = 4'b0001;
        repeat (3) @(negedge clk);
        check("R1 R6", h_o, 1'b1);            // green from its rising edge
        pins = 4'b0001;
        c_ok = 1;                              // composite wanted back while green high
        pins = 4'b0011;
        repeat (3) @(negedge clk);
        check("R6", h_o, 1'b1);

        // ---- clean start for the modelled part
        do_reset();

        // R8: leading edge in high mode with composite
        set_cfg(2'b10, 1, 1, 0, 8'd3);
        pins_next = 4'b0010; repeat (8) step("R8");
        pins_next = 4'b0000; repeat (8) step("R8");
        // R7: high mode, green only -> trailing edge
        set_cfg(2'b11, 1, 0, 0, 8'd2);
        pins_next = 4'b0011; repeat (6) step("R7");
        pins_next = 4'b0000; repeat (6) step("R7");
        // R2: mid mode ignores composite
        set_cfg(2'b01, 0, 1, 0, 8'd2);
        pins_next = 4'b1110; repeat (6) step("R2");
        pins_next = 4'b0000; repeat (6) step("R2");
        // R10: retrigger while clamp active
        set_cfg(2'b00, 0, 1, 0, 8'd6);
        for (int k = 0; k < 16; k++) begin
            pins_next = {3'b000, 1'b0} | {2'b00, k[0], 1'b0};
            step("R10");
        end
        pins_next = '0; repeat (8) step("R10");
        // R9: width zero gives no pulse
        set_cfg(2'b00, 0, 1, 0, 8'd0);
        pins_next = 4'b0010; repeat (4) step("R9");
        pins_next = 4'b0000; repeat (4) step("R9");

        // ---- constrained random
        for (int c = 0; c < 60; c++) begin
            set_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                    1'($urandom % 2), CW'($urandom % 7));
            for (int j = 0; j < 30; j++) begin
                for (int b = 0; b < 4; b++)
                    if ($urandom % 4 == 0) pins_next[b] = ~pins_next[b];
                step("");
            end
        end

        report();
    end

endmodule